// File: doc/BRIEF.md
# Wakeup Pin Interrupt Controller

This block serves three general-purpose wakeup pins. For each pin, software picks an active level, a direction and an interrupt enable. These settings live in small byte-wide registers behind a simple register bus.

A pin set as an input goes through a two-flop synchroniser. It is then turned into an active-high level by its polarity bit and filtered by a debounce counter. Pins 0 and 1 use a short debounce set by a parameter. Pin 2 uses a fixed 31 µs window, worked out from the clock frequency.

A rising active level on an enabled input pin sets a sticky status bit. The interrupt request is high while any status bit is set. Software clears a status bit by writing a 1 to it. If interrupt generation is disabled for a pin, a qualifying edge goes instead to a pulse on a separate wake-event output, provided the external wake enable for that pin is set. Setting the interrupt enable therefore takes priority over the wake path. A pin set as an output drives the level held in a data register.

Top module: `wkp_smi_ctrl`

## Requirements
- R1: After reset, every register reads 00h, smi_req is low, pin_oe and pin_out are 000 and wake_evt is 000, so all pins are active-high inputs with interrupts disabled.
- R2: Address 0 is the polarity register. Bit i (i = 0..2) set to 1 makes pin i active low, and 0 makes it active high. Bits 7:3 always read 0.
- R3: Address 1 is the control register. Bits 2:0 are the direction of pins 2..0 (1 = output). Bit 4+i is the interrupt enable of pin i. Bits 7 and 3 always read 0.
- R4: Address 2 holds output data in bits 2:0 (upper bits read 0). For each pin whose direction is output, pin_oe is 1 and pin_out equals that data bit. For an input pin, both are 0.
- R5: The active level of pin i is pin_in[i] XOR polarity bit i. Only a rise of this active level counts, so with polarity low, a falling pad sets status and a rising pad does not.
- R6: For pins 0 and 1, a change at pin_in that is driven before clock edge k and held takes effect at edge k+1+FAST_DEBOUNCE. A status bit set by it is visible right after that edge.
- R7: Pin 2 takes effect only after its new active level has held for CLK_HZ/1e6*31 cycles (edge k+1+that count). A change lasting less than that is ignored.
- R8: A qualifying rise on an input pin with its enable set sets status bit i, read at address 3 bits 2:0. smi_req is high exactly while any status bit is 1.
- R9: A pin whose direction is output, or whose enable is 0, never sets its status bit, whatever its pad does.
- R10: Writing 1 to bit i at address 3 clears status bit i, and writing 0 leaves it unchanged. If a qualifying rise arrives on the same edge as the clear, the bit stays set.
- R11: A qualifying rise on an input pin with interrupt enable 0 and wake_en[i] 1 gives a one-cycle pulse on wake_evt[i] after the same edge at which the status would have been set. While the interrupt enable is 1, the wake pulse is suppressed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe, sampled on the rising clock edge |
| reg_addr | input | 2 | Register address (0 polarity, 1 control, 2 output data, 3 status) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| pin_in | input | 3 | Pad input levels, asynchronous |
| pin_out | output | 3 | Pad output levels |
| pin_oe | output | 3 | Pad output enables |
| wake_en | input | 3 | Per-pin wake enable from elsewhere in the chip |
| wake_evt | output | 3 | One-cycle wake event pulses |
| smi_req | output | 1 | System-management interrupt request |

## Verification
A pad change driven before edge k reaches the debounced level at edge k+1+N, where N is FAST_DEBOUNCE for pins 0 and 1 and the 31 µs cycle count for pin 2. Status, smi_req and wake_evt change at that same edge. A register write lands at the edge that samples the strobe, and its effect on pin_oe, pin_out and reg_rdata shows right after it. The bench's behavioural model follows these latencies cycle by cycle and is compared in the middle of each high phase. The directed checks count exact edges: they sample one cycle before the due edge to see the old value and right after it to see the new one. The set-wins case places the clear write on exactly the due edge.

// File: rtl/wkp_pkg.sv
package wkp_pkg;

    parameter int unsigned WKP_PINS = 3;
    parameter int unsigned WKP_DW   = 8;
    parameter int unsigned WKP_AW   = 2;

    typedef enum logic [WKP_AW-1:0] {
        ADR_POLARITY = 2'd0,
        ADR_CONTROL  = 2'd1,
        ADR_OUTDATA  = 2'd2,
        ADR_STATUS   = 2'd3
    } wkp_addr_e;

    // writable-bit masks
    parameter logic [WKP_DW-1:0] MASK_POL  = 8'h07;
    parameter logic [WKP_DW-1:0] MASK_CTRL = 8'h77;
    parameter logic [WKP_DW-1:0] MASK_DOUT = 8'h07;
    parameter logic [WKP_DW-1:0] MASK_STAT = 8'h07;

    typedef struct packed {
        logic [WKP_DW-1:0] pol;
        logic [WKP_DW-1:0] ctrl;
        logic [WKP_DW-1:0] dout;
        logic [WKP_DW-1:0] stat;
    } wkp_regs_t;

    typedef struct packed {
        logic [WKP_PINS-1:0] wake;
    } wkp_top_t;

endpackage

// File: rtl/wkp_sync.sv
module wkp_sync #(
    parameter int unsigned W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] st1;
        logic [W-1:0] st2;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.st1 = d;
        s_d.st2 = s_q.st1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign q = s_q.st2;
endmodule

// File: rtl/wkp_debounce.sv
module wkp_debounce #(
    parameter int unsigned LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic rise
);
    localparam int unsigned CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    typedef struct packed {
        logic             level;
        logic [CNT_W-1:0] cnt;
    } db_t;

    db_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        rise = 1'b0;
        if (raw == s_q.level) begin
            s_d.cnt = '0;
        end else if (s_q.cnt == LAST) begin
            s_d.level = raw;
            s_d.cnt   = '0;
            rise      = raw;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // the filtered level may move only once the counter has run its full window
    assert_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(s_q.level) |-> ($past(s_q.cnt) == LAST));

    // a filtered change always follows a counter that was moving
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cnt != '0) |-> (raw != s_q.level) || $stable(s_q.level) || (s_q.cnt == '0));
endmodule

// File: rtl/wkp_regfile.sv
module wkp_regfile
    import wkp_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [WKP_AW-1:0]   addr,
    input  logic [WKP_DW-1:0]   wdata,
    output logic [WKP_DW-1:0]   rdata,
    input  logic [WKP_PINS-1:0] stat_set,
    output logic [WKP_PINS-1:0] pol,
    output logic [WKP_PINS-1:0] dir,
    output logic [WKP_PINS-1:0] en,
    output logic [WKP_PINS-1:0] dout,
    output logic [WKP_PINS-1:0] stat
);
    wkp_regs_t r_d, r_q;
    logic [WKP_DW-1:0] clr;

    always_comb begin
        r_d = r_q;
        clr = '0;
        if (we) begin
            unique case (wkp_addr_e'(addr))
                ADR_POLARITY: r_d.pol  = wdata & MASK_POL;
                ADR_CONTROL:  r_d.ctrl = wdata & MASK_CTRL;
                ADR_OUTDATA:  r_d.dout = wdata & MASK_DOUT;
                ADR_STATUS:   clr      = wdata & MASK_STAT;
                default: ;
            endcase
        end
        // a new event on the same edge beats the clear
        r_d.stat = (r_q.stat & ~clr) | {{(WKP_DW-WKP_PINS){1'b0}}, stat_set};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        unique case (wkp_addr_e'(addr))
            ADR_POLARITY: rdata = r_q.pol;
            ADR_CONTROL:  rdata = r_q.ctrl;
            ADR_OUTDATA:  rdata = r_q.dout;
            default:      rdata = r_q.stat;
        endcase
    end

    assign pol  = r_q.pol[WKP_PINS-1:0];
    assign dir  = r_q.ctrl[WKP_PINS-1:0];
    assign en   = r_q.ctrl[4 +: WKP_PINS];
    assign dout = r_q.dout[WKP_PINS-1:0];
    assign stat = r_q.stat[WKP_PINS-1:0];

    generate
        for (genvar i = 0; i < WKP_PINS; i++) begin : g_chk
            assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
                stat_set[i] |=> stat[i]);
            assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
                (we && addr == ADR_STATUS && wdata[i] && !stat_set[i]) |=> !stat[i]);
        end
    endgenerate

    assert_reserved_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == ADR_CONTROL) |=> (r_q.ctrl[7] == 1'b0 && r_q.ctrl[3] == 1'b0));
endmodule

// File: rtl/wkp_smi_ctrl.sv
module wkp_smi_ctrl
    import wkp_pkg::*;
#(
    parameter int unsigned CLK_HZ           = 100_000_000,
    parameter int unsigned SLOW_DEBOUNCE_US = 31,
    parameter int unsigned FAST_DEBOUNCE    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_we,
    input  logic [WKP_AW-1:0]   reg_addr,
    input  logic [WKP_DW-1:0]   reg_wdata,
    output logic [WKP_DW-1:0]   reg_rdata,
    input  logic [WKP_PINS-1:0] pin_in,
    output logic [WKP_PINS-1:0] pin_out,
    output logic [WKP_PINS-1:0] pin_oe,
    input  logic [WKP_PINS-1:0] wake_en,
    output logic [WKP_PINS-1:0] wake_evt,
    output logic                smi_req
);
    localparam int unsigned SLOW_CYC = (CLK_HZ / 1_000_000) * SLOW_DEBOUNCE_US;
    localparam int unsigned SLOW_PIN = WKP_PINS - 1;

    logic [WKP_PINS-1:0] pin_s, act, rise;
    logic [WKP_PINS-1:0] pol, dir, en, dout, stat;
    logic [WKP_PINS-1:0] hit;
    wkp_top_t s_d, s_q;

    wkp_sync #(.W(WKP_PINS)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pin_s)
    );

    generate
        for (genvar i = 0; i < WKP_PINS; i++) begin : g_pin
            localparam int unsigned LIM = (i == SLOW_PIN) ? SLOW_CYC : FAST_DEBOUNCE;
            assign act[i] = pin_s[i] ^ pol[i];
            wkp_debounce #(.LIMIT(LIM)) i_db (
                .clk   (clk),
                .rst_n (rst_n),
                .raw   (act[i]),
                .rise  (rise[i])
            );

            assert_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(stat[i]) |-> $past(en[i] && !dir[i]));
            assert_wake_R11: assert property (@(posedge clk) disable iff (!rst_n)
                wake_evt[i] |-> ($past(!en[i]) && !$past(wake_evt[i])));
        end
    endgenerate

    wkp_regfile i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (reg_we),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .stat_set (hit),
        .pol      (pol),
        .dir      (dir),
        .en       (en),
        .dout     (dout),
        .stat     (stat)
    );

    always_comb begin
        hit       = rise & ~dir & en;
        s_d       = s_q;
        s_d.wake  = rise & ~dir & ~en & wake_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign wake_evt = s_q.wake;
    assign smi_req  = |stat;
    assign pin_oe   = dir;
    assign pin_out  = dout & dir;

    assert_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(smi_req) |-> $past(|(rise & en & ~dir)));
endmodule

// File: tb/test_wkp_smi_ctrl.sv
module test_wkp_smi_ctrl;
    localparam int unsigned CLK_HZ = 100_000_000;
    localparam int unsigned DBF    = 4;
    localparam int unsigned SLOW   = (CLK_HZ / 1_000_000) * 31;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic [2:0] pin_in = 3'b000;
    logic [2:0] pin_out, pin_oe, wake_en, wake_evt;
    logic       smi_req;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    initial wake_en = 3'b000;
    always #5 clk = ~clk;

    wkp_smi_ctrl #(.CLK_HZ(CLK_HZ), .SLOW_DEBOUNCE_US(31), .FAST_DEBOUNCE(DBF)) i_wkp_smi_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .wake_en(wake_en),
        .wake_evt(wake_evt), .smi_req(smi_req)
    );

    // behavioural reference
    logic [7:0] m_pol, m_ctrl, m_dout, m_stat;
    logic [2:0] m_s1, m_s2, m_lvl, m_rise, m_wake;
    int m_run [3];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pol = 0; m_ctrl = 0; m_dout = 0; m_stat = 0;
            m_s1 = 0; m_s2 = 0; m_lvl = 0; m_wake = 0;
            for (int i = 0; i < 3; i++) m_run[i] = 0;
        end else begin
            m_rise = 3'b000;
            for (int i = 0; i < 3; i++) begin
                int  lim;
                logic a;
                lim = (i == 2) ? SLOW : DBF;
                a = m_s2[i] ^ m_pol[i];
                if (a == m_lvl[i]) m_run[i] = 0;
                else if (m_run[i] == lim - 1) begin
                    m_lvl[i] = a; m_run[i] = 0; m_rise[i] = a;
                end else m_run[i] = m_run[i] + 1;
            end
            m_wake = m_rise & ~m_ctrl[2:0] & ~m_ctrl[6:4] & wake_en;
            if (reg_we) begin
                case (reg_addr)
                    2'd0: m_pol  = reg_wdata & 8'h07;
                    2'd1: m_ctrl = reg_wdata & 8'h77;
                    2'd2: m_dout = reg_wdata & 8'h07;
                    default: m_stat = m_stat & ~reg_wdata;
                endcase
            end
            m_stat = m_stat | {5'b0, m_rise & ~m_ctrl[2:0] & m_ctrl[6:4]};
            m_s2 = m_s1;
            m_s1 = pin_in;
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] m_read(input logic [1:0] a);
        case (a)
            2'd0: return m_pol;
            2'd1: return m_ctrl;
            2'd2: return m_dout;
            default: return m_stat;
        endcase
    endfunction

    // compare mid high phase, away from both edges
    always @(posedge clk) begin
        #3;
        if (rst_n && !done) begin
            chk("R8 smi_req", {7'b0, smi_req}, {7'b0, |m_stat});
            chk("R4 pin_oe", {5'b0, pin_oe}, {5'b0, m_ctrl[2:0]});
            chk("R4 pin_out", {5'b0, pin_out}, {5'b0, m_dout[2:0] & m_ctrl[2:0]});
            chk("R11 wake_evt", {5'b0, wake_evt}, {5'b0, m_wake});
            chk("R3 R10 reg_rdata", reg_rdata, m_read(reg_addr));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input string req, input logic [1:0] a, input logic [7:0] exp);
        reg_addr = a;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        for (int a = 0; a < 4; a++) rd("R1 reset reg", 2'(a), 8'h00);
        chk("R1 smi_req", {7'b0, smi_req}, 8'h00);
        chk("R1 pin_oe", {5'b0, pin_oe}, 8'h00);
        chk("R1 wake_evt", {5'b0, wake_evt}, 8'h00);

        // R2 / R3 reserved bits
        wr(2'd0, 8'hFF); rd("R2 polarity readback", 2'd0, 8'h07);
        wr(2'd0, 8'h00);
        wr(2'd1, 8'hFF); rd("R3 control readback", 2'd1, 8'h77);
        chk("R4 all outputs", {5'b0, pin_oe}, 8'h07);
        wr(2'd1, 8'h00);

        // R4 output drive
        wr(2'd2, 8'h07); wr(2'd1, 8'h05);
        chk("R4 oe", {5'b0, pin_oe}, 8'h05);
        chk("R4 out", {5'b0, pin_out}, 8'h05);
        wr(2'd2, 8'h02);
        chk("R4 out input pin low", {5'b0, pin_out}, 8'h00);
        wr(2'd1, 8'h00);

        // R6 exact latency on pin 0
        wr(2'd1, 8'h10);
        pin_in[0] = 1'b1;
        tick(DBF + 1); chk("R6 before due edge", {7'b0, smi_req}, 8'h00);
        tick(1);       chk("R6 at due edge", {7'b0, smi_req}, 8'h01);
        rd("R8 status bit0", 2'd3, 8'h01);

        // R10 clear, then set wins
        wr(2'd3, 8'h01);
        rd("R10 cleared", 2'd3, 8'h00);
        chk("R10 no re-set while held", {7'b0, smi_req}, 8'h00);
        pin_in[0] = 1'b0; tick(20);
        pin_in[0] = 1'b1;
        tick(DBF + 1);
        wr(2'd3, 8'h01);
        rd("R10 set wins over clear", 2'd3, 8'h01);
        wr(2'd3, 8'h01);
        rd("R10 cleared again", 2'd3, 8'h00);

        // R5 polarity inversion on pin 1
        wr(2'd1, 8'h20);
        wr(2'd0, 8'h02);
        tick(DBF + 5);
        rd("R5 low-active pin sets status", 2'd3, 8'h02);
        wr(2'd3, 8'h02);
        pin_in[1] = 1'b1; tick(20);
        chk("R5 rising pad ignored when low-active", {7'b0, smi_req}, 8'h00);
        pin_in[1] = 1'b0; tick(20);
        rd("R5 falling pad sets", 2'd3, 8'h02);
        wr(2'd3, 8'h02);
        wr(2'd0, 8'h00);

        // R9 output mode and disabled
        wr(2'd1, 8'h11);
        pin_in[0] = 1'b0; tick(10);
        pin_in[0] = 1'b1; tick(10);
        chk("R9 output pin no status", {7'b0, smi_req}, 8'h00);
        wr(2'd1, 8'h00);
        pin_in[0] = 1'b0; tick(10);
        pin_in[0] = 1'b1; tick(10);
        chk("R9 disabled pin no status", {7'b0, smi_req}, 8'h00);
        pin_in[0] = 1'b0; tick(10);

        // R11 wake path
        wake_en = 3'b010;
        pin_in[1] = 1'b1;
        tick(DBF + 1); chk("R11 wake before due", {5'b0, wake_evt}, 8'h00);
        tick(1);       chk("R11 wake pulse", {5'b0, wake_evt}, 8'h02);
        tick(1);       chk("R11 wake one cycle", {5'b0, wake_evt}, 8'h00);
        chk("R11 no smi on wake", {7'b0, smi_req}, 8'h00);
        pin_in[1] = 1'b0; tick(10);
        wr(2'd1, 8'h20);
        pin_in[1] = 1'b1;
        tick(DBF + 2);
        chk("R11 wake suppressed", {5'b0, wake_evt}, 8'h00);
        chk("R11 smi instead", {7'b0, smi_req}, 8'h01);
        wr(2'd3, 8'h02);
        pin_in[1] = 1'b0; wake_en = 3'b000;
        tick(10);

        // R7 slow debounce on pin 2
        wr(2'd1, 8'h40);
        pin_in[2] = 1'b1; tick(SLOW - 100);
        pin_in[2] = 1'b0; tick(SLOW + 10);
        chk("R7 short pulse ignored", {7'b0, smi_req}, 8'h00);
        pin_in[2] = 1'b1;
        tick(SLOW + 1); chk("R7 before window ends", {7'b0, smi_req}, 8'h00);
        tick(1);        chk("R7 at window end", {7'b0, smi_req}, 8'h01);
        rd("R7 status bit2", 2'd3, 8'h04);
        wr(2'd3, 8'h04);
        tick(4);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule